// File: doc/BRIEF.md
# Packed Compare and Arithmetic ALU

This block is a 64-bit lane-parallel arithmetic unit for a SIMD datapath. It treats its two operands as eight byte lanes, four halfword lanes or two word lanes, and applies one operation to every lane at once. The operations are equality and greater-than compares, signed and unsigned minimum and maximum, wrapping and saturating add and subtract, and unsigned averaging with an optional round-up bit.

Alongside the 64-bit result the block produces a 32-bit status word. It holds negative, zero, carry and overflow indicators for each lane. The position of each lane's field depends on the lane size. A request is presented with `in_valid`. Its result and status appear on registered outputs one clock later, qualified by `out_valid`. Operand registers and instruction decoding belong to the surrounding pipeline.

Top module: `packed_lane_alu`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `result` and `flags`. A request with `in_valid` high at a rising edge appears on the outputs after that edge with `out_valid` high. While `in_valid` is low, `out_valid` is low and `result` and `flags` keep their last values.
- R2: `lane_sz` selects the lane width: 0 means 8 bits, 1 means 16 bits, and both 2 and 3 mean 32 bits.
- R3: Operation codes 0 (equal), 1 (signed greater-than) and 2 (unsigned greater-than) fill a lane with all ones when `a` relation `b` holds and with zeros otherwise.
- R4: Codes 3 (signed min), 4 (unsigned min), 5 (signed max) and 6 (unsigned max) copy the entire lane from whichever operand wins.
- R5: Codes 7 (a+b) and 8 (a-b) wrap within each lane and never carry or borrow into a neighbouring lane.
- R6: Saturating codes clamp instead of wrapping. Code 9 (unsigned add) stops at all ones and code 11 (unsigned subtract) stops at zero. Code 10 (signed add) and code 12 (signed subtract) stop at the signed maximum or minimum.
- R7: Code 13 returns (a + b + `rnd`) >> 1 per lane, computed on unsigned lane values without losing the carry bit.
- R8: Each lane has a 4-bit field ordered N, Z, C, V from its top bit down. In byte mode lane i uses bits 4i+3..4i. In halfword mode lane h uses bits 8h+7..8h+4. In word mode lane w uses bits 16w+15..16w+12. Every other status bit reads zero.
- R9: N is the top bit of the lane result and Z is set when the lane result is zero. After an average (code 13), only Z bits may be set.
- R10: C is set in a lane that an unsigned saturating operation (9, 11) clamped. V is set in a lane that a signed saturating operation (10, 12) clamped. Both are zero for every other operation.
- R11: Codes 14 and 15 return a zero result, with only the Z bit set in each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| lane_sz | input | 2 | Lane width select |
| op_sel | input | 4 | Operation code |
| rnd | input | 1 | Round-up bit for averaging |
| out_valid | output | 1 | Result qualifier |
| result | output | 64 | Lane-wise result |
| flags | output | 32 | Per-lane N/Z/C/V status |

## Verification
Clamping and zero detection can land on the same lane in the same cycle. This happens when an unsigned saturating subtract clamps a lane to zero, which must set Z and C together while a neighbouring lane that did not clamp shows neither C nor a false Z. The bench provokes this with operands in which only some lanes underflow, in every lane size. Each status bit is judged against a lane model kept in the scoreboard. Back-to-back requests with different sizes and operations check that the field stride and the clamp indicators follow each request rather than its predecessor.

// File: rtl/plalu_pkg.sv
package plalu_pkg;

  typedef enum logic [3:0] {
    OP_EQ    = 4'd0,
    OP_GTS   = 4'd1,
    OP_GTU   = 4'd2,
    OP_MINS  = 4'd3,
    OP_MINU  = 4'd4,
    OP_MAXS  = 4'd5,
    OP_MAXU  = 4'd6,
    OP_ADD   = 4'd7,
    OP_SUB   = 4'd8,
    OP_ADDUS = 4'd9,
    OP_ADDSS = 4'd10,
    OP_SUBUS = 4'd11,
    OP_SUBSS = 4'd12,
    OP_AVG   = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } lflag_t;

endpackage

// File: rtl/plalu_lane.sv
module plalu_lane
  import plalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  input  logic         rnd,
  output logic [W-1:0] res,
  output lflag_t       fl
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum, dif, avg;
  logic         gts, gtu, ovf_add, ovf_sub;
  logic [W-1:0] r;
  logic         c_set, v_set;

  always_comb begin
    sum     = {1'b0, a} + {1'b0, b};
    dif     = {1'b0, a} - {1'b0, b};
    avg     = sum + {{W{1'b0}}, rnd};
    gts     = $signed(a) > $signed(b);
    gtu     = a > b;
    ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    c_set   = 1'b0;
    v_set   = 1'b0;
    unique case (op)
      OP_EQ:   r = (a == b) ? '1 : '0;
      OP_GTS:  r = gts ? '1 : '0;
      OP_GTU:  r = gtu ? '1 : '0;
      OP_MINS: r = gts ? b : a;
      OP_MINU: r = gtu ? b : a;
      OP_MAXS: r = gts ? a : b;
      OP_MAXU: r = gtu ? a : b;
      OP_ADD:  r = sum[W-1:0];
      OP_SUB:  r = dif[W-1:0];
      OP_ADDUS: begin
        c_set = sum[W];
        r     = sum[W] ? '1 : sum[W-1:0];
      end
      OP_SUBUS: begin
        c_set = dif[W];
        r     = dif[W] ? '0 : dif[W-1:0];
      end
      OP_ADDSS: begin
        v_set = ovf_add;
        r     = ovf_add ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
      end
      OP_SUBSS: begin
        v_set = ovf_sub;
        r     = ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif[W-1:0];
      end
      OP_AVG:  r = avg[W:1];
      default: r = '0;
    endcase
    res  = r;
    fl.n = r[W-1] && (op != OP_AVG);
    fl.z = (r == '0);
    fl.c = c_set;
    fl.v = v_set;
  end

endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
  import plalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic [1:0]          lane_sz,
  input  logic [3:0]          op_sel,
  input  logic                rnd,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/2-1:0] flags
);

  localparam int FLAG_W = DATA_W / 2;
  localparam int NB     = DATA_W / 8;
  localparam int NH     = DATA_W / 16;
  localparam int NW     = DATA_W / 32;

  op_e op;
  assign op = op_e'(op_sel);

  logic [DATA_W-1:0] res_b, res_h, res_w;
  logic [FLAG_W-1:0] flg_b, flg_h, flg_w;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    lflag_t fl;
    plalu_lane #(.W(8)) u_lane (
      .a(opnd_a[8*g +: 8]), .b(opnd_b[8*g +: 8]), .op(op), .rnd(rnd),
      .res(res_b[8*g +: 8]), .fl(fl)
    );
    assign flg_b[4*g +: 4] = fl;
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    lflag_t fl;
    plalu_lane #(.W(16)) u_lane (
      .a(opnd_a[16*g +: 16]), .b(opnd_b[16*g +: 16]), .op(op), .rnd(rnd),
      .res(res_h[16*g +: 16]), .fl(fl)
    );
    assign flg_h[8*g+4 +: 4] = fl;
    assign flg_h[8*g +: 4]   = '0;
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    lflag_t fl;
    plalu_lane #(.W(32)) u_lane (
      .a(opnd_a[32*g +: 32]), .b(opnd_b[32*g +: 32]), .op(op), .rnd(rnd),
      .res(res_w[32*g +: 32]), .fl(fl)
    );
    assign flg_w[16*g+12 +: 4] = fl;
    assign flg_w[16*g +: 12]   = '0;
  end

  logic [DATA_W-1:0] res_mux;
  logic [FLAG_W-1:0] flg_mux;

  always_comb begin
    unique case (lane_sz)
      2'd0:    begin res_mux = res_b; flg_mux = flg_b; end
      2'd1:    begin res_mux = res_h; flg_mux = flg_h; end
      default: begin res_mux = res_w; flg_mux = flg_w; end
    endcase
  end

  op_e        op_q;
  logic [1:0] sz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      op_q      <= OP_EQ;
      sz_q      <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_mux;
        flags  <= flg_mux;
        op_q   <= op;
        sz_q   <= lane_sz;
      end
    end
  end

  // Mask of one status-field position (0=V,1=C,2=Z,3=N) for a lane size.
  function automatic logic [FLAG_W-1:0] fld_mask(input logic [1:0] sz, input int pos);
    int stride;
    logic [FLAG_W-1:0] m;
    stride = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 16;
    m = '0;
    for (int k = 0; k < FLAG_W; k++)
      if ((k % stride) == stride - 4 + pos) m[k] = 1'b1;
    return m;
  endfunction

  logic is_sat_q;
  assign is_sat_q = (op_q == OP_ADDUS) || (op_q == OP_SUBUS) ||
                    (op_q == OP_ADDSS) || (op_q == OP_SUBSS);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && flags == '0));

  a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags)));

  a_r8_undef_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags & ~(fld_mask(sz_q, 0) | fld_mask(sz_q, 1) |
                             fld_mask(sz_q, 2) | fld_mask(sz_q, 3))) == '0);

  a_r9_avg_zonly: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_AVG) |->
      (flags & ~fld_mask(sz_q, 2)) == '0);

  a_r10_cv_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !is_sat_q) |->
      (flags & (fld_mask(sz_q, 0) | fld_mask(sz_q, 1))) == '0);

  for (genvar g = 0; g < NB; g++) begin : g_chk
    a_r9_zflag_byte: assert property (@(posedge clk) disable iff (rst)
      (out_valid && sz_q == 2'd0) |->
        (flags[4*g+2] == (result[8*g +: 8] == 8'd0)));
    a_r3_cmp_fill: assert property (@(posedge clk) disable iff (rst)
      (out_valid && sz_q == 2'd0 && op_q inside {OP_EQ, OP_GTS, OP_GTU}) |->
        (result[8*g +: 8] == 8'h00 || result[8*g +: 8] == 8'hFF));
  end

endmodule

// File: tb/packed_lane_alu_tb_top.sv
module packed_lane_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [1:0]  lane_sz = '0;
  logic [3:0]  op_sel = '0;
  logic        rnd = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flags;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cycles = 0;

  logic [63:0] exp_r[$];
  logic [31:0] exp_f[$];
  string       exp_t[$];
  logic [63:0] last_r;
  logic [31:0] last_f;

  always #10 clk = ~clk;

  packed_lane_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .lane_sz(lane_sz), .op_sel(op_sel), .rnd(rnd),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] sz, input logic [3:0] op,
                                input logic rn, output logic [63:0] r,
                                output logic [31:0] f);
    int w, nl, st, top;
    longint unsigned m, sb, x, y, o, s;
    longint xs, ys, t, smax, smin;
    bit n, z, c, v;
    w  = (sz >= 2) ? 32 : (8 << sz);
    nl = 64 / w;
    st = w / 2;
    m  = (64'd1 << w) - 1;
    sb = 64'd1 << (w - 1);
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    r = '0;
    f = '0;
    for (int l = 0; l < nl; l++) begin
      x  = (a >> (l * w)) & m;
      y  = (b >> (l * w)) & m;
      xs = longint'(x ^ sb) - longint'(sb);
      ys = longint'(y ^ sb) - longint'(sb);
      c = 0; v = 0;
      case (op)
        4'd0: o = (x == y) ? m : 0;
        4'd1: o = (xs > ys) ? m : 0;
        4'd2: o = (x > y) ? m : 0;
        4'd3: o = (xs < ys) ? x : y;
        4'd4: o = (x < y) ? x : y;
        4'd5: o = (xs > ys) ? x : y;
        4'd6: o = (x > y) ? x : y;
        4'd7: o = (x + y) & m;
        4'd8: o = (x - y) & m;
        4'd9: begin s = x + y; if (s > m) begin o = m; c = 1; end else o = s; end
        4'd11: begin if (x < y) begin o = 0; c = 1; end else o = x - y; end
        4'd10, 4'd12: begin
          t = (op == 4'd10) ? xs + ys : xs - ys;
          if (t > smax) begin t = smax; v = 1; end
          else if (t < smin) begin t = smin; v = 1; end
          o = longint'(t) & m;
        end
        4'd13: o = (x + y + longint'(rn)) >> 1;
        default: o = 0;
      endcase
      n = ((o >> (w - 1)) & 1) != 0;
      z = (o == 0);
      if (op == 4'd13) n = 0;
      top = (l + 1) * st - 1;
      f[top] = n; f[top-1] = z; f[top-2] = c; f[top-3] = v;
      r = r | (o << (l * w));
    end
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2:          return "R3";
      4'd3, 4'd4, 4'd5, 4'd6:    return "R4";
      4'd7, 4'd8:                return "R5";
      4'd9, 4'd10, 4'd11, 4'd12: return "R6";
      4'd13:                     return "R7";
      default:                   return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                      input logic [3:0] op, input logic rn, input string tag);
    logic [63:0] r;
    logic [31:0] f;
    model(a, b, sz, op, rn, r, f);
    opnd_a = a; opnd_b = b; lane_sz = sz; op_sel = op; rnd = rn; in_valid = 1'b1;
    exp_r.push_back(r); exp_f.push_back(f); exp_t.push_back(tag);
    last_r = r; last_f = f;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever the design presents a result.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_r.size() == 0) begin
        check("R1", "unexpected out_valid", 64'd1, 64'd0);
      end else begin
        automatic logic [63:0] er = exp_r.pop_front();
        automatic logic [31:0] ef = exp_f.pop_front();
        automatic string       et = exp_t.pop_front();
        check(et, "result", result, er);
        check({et, "/R8"}, "flags", {32'd0, flags}, {32'd0, ef});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1", "result after reset", result, 64'd0);
    check("R1", "flags after reset", {32'd0, flags}, 64'd0);

    // R3 compares across sizes
    send(64'h11_22_80_7F_00_FF_05_05, 64'h11_23_7F_80_00_FE_05_06, 2'd0, 4'd0, 0, "R3");
    send(64'h11_22_80_7F_00_FF_05_05, 64'h11_23_7F_80_00_FE_05_06, 2'd0, 4'd1, 0, "R3");
    send(64'h11_22_80_7F_00_FF_05_05, 64'h11_23_7F_80_00_FE_05_06, 2'd0, 4'd2, 0, "R3");
    send(64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000, 2'd1, 4'd1, 0, "R3");
    // R4 min/max, R2 lane size 3 behaves as words
    send(64'h8000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF, 2'd2, 4'd3, 0, "R4");
    send(64'h8000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF, 2'd3, 4'd6, 0, "R2");
    send(64'h80_01_FF_00_7F_10_20_30, 64'h7F_02_01_00_80_0F_21_30, 2'd0, 4'd5, 0, "R4");
    send(64'h8000_0001_FFFF_0000, 64'h7FFF_0002_0001_0000, 2'd1, 4'd4, 0, "R4");
    // R5 wrapping, no carry between lanes
    send(64'hFF_FF_FF_FF_FF_FF_FF_FF, 64'h01_01_01_01_01_01_01_01, 2'd0, 4'd7, 0, "R5");
    send(64'h0000_0000_0000_0000, 64'h0001_0000_0001_0000, 2'd1, 4'd8, 0, "R5");
    // R6 / R10 saturation, clamps to zero in only some lanes
    send(64'hF0_10_00_05_FF_00_80_01, 64'h20_20_01_05_01_00_80_02, 2'd0, 4'd11, 0, "R10");
    send(64'hFFF0_0010_0000_8000, 64'h0020_0020_0000_8000, 2'd1, 4'd9, 0, "R6");
    send(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'd2, 4'd10, 0, "R6");
    send(64'h7F_80_00_10_80_7F_01_FF, 64'h80_01_7F_10_7F_FF_02_01, 2'd0, 4'd12, 0, "R10");
    send(64'h8000_0000_0005_0003, 64'h0001_0000_0006_0003, 2'd1, 4'd11, 0, "R6");
    // R7 average with and without round-up, R9 only Z flags
    send(64'hFF_FF_01_00_03_80_7F_00, 64'hFF_00_00_00_04_80_80_01, 2'd0, 4'd13, 0, "R7");
    send(64'hFF_FF_01_00_03_80_7F_00, 64'hFF_00_00_00_04_80_80_01, 2'd0, 4'd13, 1, "R9");
    send(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0001, 2'd2, 4'd13, 1, "R7");
    // R11 reserved codes
    send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd1, 4'd14, 0, "R11");
    send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd0, 4'd15, 1, "R11");
    idle(4);
    // R1: outputs hold while idle
    check("R1", "held result", result, last_r);
    check("R1", "held flags", {32'd0, flags}, {32'd0, last_f});
    check("R1", "out_valid idle", {63'd0, out_valid}, 64'd0);

    // Random back-to-back traffic, each check tagged by operation
    for (int i = 0; i < 400; i++) begin
      automatic logic [3:0] op = 4'($urandom_range(0, 15));
      send({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom_range(0, 3)),
           op, 1'($urandom_range(0, 1)), req_of(op));
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);
    check("R1", "scoreboard drained", 64'(exp_r.size()), 64'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule